// File: doc/BRIEF.md
# Width-Selectable Serial-to-Parallel Converter with Phased Word Clock

This block takes a serial NRZ bit stream, one bit per bit-clock cycle, and packs it into parallel words of 2, 4 or 8 bits. A two-bit width select picks the word size at run time.

Next to the data bus it drives a word clock. The word clock is a registered signal in the bit-clock domain. It runs at the bit rate divided by the word width. Its rising edge can be placed at one of four quarter-period offsets from the moment the data bus updates, so a downstream register can sample the bus with whatever margin the board needs.

When either select input changes, the block drops the word it was assembling and starts a new one. The bus holds its last complete word until the next word is finished.

Top module: `wsel_deser`

## Requirements
- R1: The width select sets the word size N: 2'b00 gives 2 bits, 2'b01 gives 4 bits, and both 2'b10 and 2'b11 give 8 bits.
- R2: The first bit received in a word appears on `dout[0]`, and each later bit goes to the next higher position.
- R3: A new word in 2-bit or 4-bit mode drives every `dout` bit at position N and above to zero.
- R4: `dout` changes only at the clock edge that samples the last bit of a word; the new word is visible right after that edge. Between updates `dout` holds its value for the whole word period.
- R5: `wclk` repeats every N bit-clock cycles and stays high for N/2 of them.
- R6: Let position q be the number of edges since the last word update (0 to N-1). `wclk` is high exactly when ((q - P) mod N) < N/2, where P = floor(psel * N / 4). This gives P = 0,0,1,1 for N=2, P = 0,1,2,3 for N=4 and P = 0,2,4,6 for N=8. Its rising edge therefore comes P cycles after the update.
- R7: At the first edge that samples a changed `wsel` or `psel`:
  - the bit presented at that edge is discarded, together with the partial word;
  - `dout` keeps its value;
  - position q becomes 0, and `wclk` follows R6 from that position;
  - the next bit is bit 0 of a new word.
- R8: `rst` is synchronous and active high. It clears `dout` and `wclk` to 0. The first bit sampled after `rst` falls is bit 0 of a word, and no restart follows the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial NRZ data |
| wsel | input | 2 | Word width select (R1) |
| psel | input | 2 | Word clock phase select (R6) |
| dout | output | W (8) | Parallel word; bit 0 holds the first bit received |
| wclk | output | 1 | Word clock, registered in the bit-clock domain |

## Verification
The bench builds the block with its default W = 8. That is the only width at which all three word sizes and all four phase settings can be reached, so it walks all twelve combinations with a pseudo-random bit stream. In every cycle it checks the word clock level against the phase formula, and at every boundary it checks the word, its zeroed upper bits and that the bus held between updates. Directed cases cover reset, the width select value that aliases to 8 bits, and a select change in the middle of a word.

// File: rtl/wsel_deser.sv
module wsel_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic [1:0]   wsel,
  input  logic [1:0]   psel,
  output logic [W-1:0] dout,
  output logic         wclk
);
  localparam int CW = $clog2(W);
  localparam int AW = CW + 3;

  logic [1:0]    wq, pq;
  logic [CW-1:0] cnt, nxt, poff;
  logic [CW:0]   n;
  logic [AW-1:0] d, dm;
  logic [W-1:0]  acc, word, mask;
  logic          restart, upd, wclk_n;

  assign n = (wsel == 2'd0) ? (CW+1)'(2) :
             (wsel == 2'd1) ? (CW+1)'(4) : (CW+1)'(W);
  assign poff    = CW'((AW'(psel) * AW'(n)) >> 2);
  assign restart = (wsel != wq) || (psel != pq);
  assign upd     = !restart && (cnt == CW'(n - 1'b1));
  assign nxt     = (restart || upd) ? '0 : cnt + 1'b1;
  assign mask    = W'((AW'(1) << n) - AW'(1));
  assign d       = AW'(nxt) + AW'(n) - AW'(poff);
  assign dm      = (d >= AW'(n)) ? d - AW'(n) : d;
  assign wclk_n  = dm < AW'(n >> 1);

  always_comb begin
    word      = acc;
    word[cnt] = sdi;
    word      = word & mask;
  end

  always_ff @(posedge clk) begin
    wq <= wsel;
    pq <= psel;
    if (rst) begin
      cnt  <= '0;
      acc  <= '0;
      dout <= '0;
      wclk <= 1'b0;
    end else begin
      cnt  <= nxt;
      wclk <= wclk_n;
      if (!restart) acc[cnt] <= sdi;
      if (upd) dout <= word;
    end
  end
endmodule

module wsel_deser_chk #(
  parameter int W  = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          upd,
  input logic          restart,
  input logic          wclk,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] poff,
  input logic [CW:0]   n,
  input logic [W-1:0]  dout
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst || restart) armed <= 1'b0;
    else if (upd)       armed <= 1'b1;
  end

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(upd) |-> (dout >> $past(n)) == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(upd) |-> dout == $past(dout));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0) && $stable(dout));

  a_r6_rise_pos: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(wclk)) |-> cnt == poff);
endmodule

bind wsel_deser wsel_deser_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .restart(restart), .wclk(wclk),
  .cnt(cnt), .poff(poff), .n(n), .dout(dout)
);

// File: tb/wsel_deser_test.sv
`timescale 1ns/1ps
module wsel_deser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sdi = 1'b0;
  logic [1:0] wsel = 2'd0;
  logic [1:0] psel = 2'd0;
  logic [7:0] dout;
  logic       wclk;
  int         nvec = 0;
  int         nerr = 0;
  logic [6:0] lf = 7'h5A;

  always #2 clk = ~clk;

  wsel_deser uut (.clk(clk), .rst(rst), .sdi(sdi), .wsel(wsel), .psel(psel),
                  .dout(dout), .wclk(wclk));

  // {wsel, psel, N, P}
  localparam logic [11:0] VEC [12] = '{
    {2'd0, 2'd0, 4'd2, 4'd0}, {2'd0, 2'd1, 4'd2, 4'd0},
    {2'd0, 2'd2, 4'd2, 4'd1}, {2'd0, 2'd3, 4'd2, 4'd1},
    {2'd1, 2'd0, 4'd4, 4'd0}, {2'd1, 2'd1, 4'd4, 4'd1},
    {2'd1, 2'd2, 4'd4, 4'd2}, {2'd1, 2'd3, 4'd4, 4'd3},
    {2'd2, 2'd0, 4'd8, 4'd0}, {2'd2, 2'd1, 4'd8, 4'd2},
    {2'd2, 2'd2, 4'd8, 4'd4}, {2'd2, 2'd3, 4'd8, 4'd6}
  };

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] w, input logic [1:0] p);
    @(negedge clk);
    rst = 1'b1; wsel = w; psel = p; sdi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(dout == 8'h00, "R8 dout after reset", dout, 8'h00);
    chk(wclk == 1'b0, "R8 wclk after reset", {7'd0, wclk}, 8'h00);
  endtask

  task automatic run(input int n, input int p, input int words, input string tag);
    logic [7:0] acc  = 8'h00;
    logic [7:0] prev = 8'h00;
    for (int k = 0; k < n * words; k++) begin
      bit b;
      int q;
      bit ew;
      b = lf[6];
      lf = {lf[5:0], lf[6] ^ lf[5]};
      sdi = b;
      acc[k % n] = b;
      @(posedge clk);
      @(negedge clk);
      q  = (k + 1) % n;
      ew = ((q - p + n) % n) < (n / 2);
      chk(wclk == ew, {tag, " R5 R6 wclk level"}, {7'd0, wclk}, {7'd0, ew});
      if (k % n == n - 1) begin
        chk(dout == acc, {tag, " R2 R4 word"}, dout, acc);
        chk((dout >> n) == 8'h00, {tag, " R3 upper bits"}, dout >> n, 8'h00);
        prev = acc;
        acc  = 8'h00;
      end else begin
        chk(dout == prev, {tag, " R4 hold"}, dout, prev);
      end
    end
  endtask

  task automatic send(input bit b);
    sdi = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) begin
      do_reset(VEC[i][11:10], VEC[i][9:8]);
      run(int'(VEC[i][7:4]), int'(VEC[i][3:0]), 5, $sformatf("R1 w%0d p%0d", VEC[i][11:10], VEC[i][9:8]));
    end

    // R1: select 2'b11 aliases to 8 bits, phase 1 gives P=2
    do_reset(2'd3, 2'd1);
    run(8, 2, 4, "R1 w3 alias");

    // R7: change width in mid-word
    do_reset(2'd2, 2'd0);
    send(1'b1); send(1'b1); send(1'b1);
    chk(dout == 8'h00, "R7 no update before change", dout, 8'h00);
    wsel = 2'd1;
    send(1'b0);
    chk(dout == 8'h00, "R7 dout kept on restart", dout, 8'h00);
    chk(wclk == 1'b1, "R7 wclk realigned to position 0", {7'd0, wclk}, 8'h01);
    send(1'b1); send(1'b0); send(1'b1);
    chk(dout == 8'h00, "R7 R4 no early update", dout, 8'h00);
    send(1'b1);
    chk(dout == 8'h0D, "R7 R2 fresh word after restart", dout, 8'h0D);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule